// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter with Global Delivery

This block sits between the interrupt source controllers of a chip and a small set of processors. It takes prioritized requests, each tagged with a target server number, and hands each request to one processor's presentation unit. A request aimed at a processor's own server number goes straight to that processor. A request aimed at the global server number goes to one processor picked round-robin from those marked available. Every processor has one pending slot for each priority level, a current processor priority (CPPR), and a single interrupt line.

Priorities are 8 bits with an inverted sense: a smaller value is more favored. A stored request raises its processor's line only when its priority is numerically below that processor's CPPR. Software on the processor reads the pending-source register to accept the most favored eligible request. That read returns the source number and raises the CPPR to the request's priority in one step. Software ends the interrupt by writing the same register with a priority to restore and the source number. The block then pulses an end-of-interrupt notice to the source controllers. Any request that cannot be held is handed straight back to the sources on a return output, so the source controller can signal it again later.

Top module: `ipc_top`

## Requirements
- R1: After reset every CPPR is 0x00, no interrupt line is high, the return and end-of-interrupt outputs are low, and the first global delivery goes to the lowest-numbered available processor.
- R2: A stored request drives its processor's interrupt line only while its priority is numerically lower than that processor's CPPR; with CPPR 0x00 the line stays low whatever is pending.
- R3: A read of the pending-source register (bus_reg = 1) returns the source number in bits [12:0] and the CPPR in bits [31:24]. A source number is the 9-bit bus unit identifier in bits [12:4] and the 4-bit index in bits [3:0]. When nothing is eligible the read returns 0 in bits [12:0] and leaves the CPPR unchanged.
- R4: An accepting read with an eligible request returns the most favored eligible source and sets the CPPR to that priority. On the next cycle the line is low unless a more favored request has arrived since.
- R5: A write to the pending-source register sets the CPPR to bits [31:24]. It frees the slot at the previous CPPR level if that slot is in service with the written source number. For a non-zero written source, eoi_valid pulses with that source on the next cycle.
- R6: Each processor holds at most one request per priority level. A new request that meets a waiting request at the same level keeps the lower source number and returns the other. A new request that meets an in-service slot is returned.
- R7: Server numbers 0 to N_CPU-1 address one processor directly and 0xFF is the global server. A request to any other server number is returned.
- R8: A global request goes to the first processor with its available-mask bit set, scanning upward from the processor after the last global pick and wrapping around.
- R9: A global request while the available mask is all zero is returned and leaves the round-robin position unchanged.
- R10: A request at priority 0xFF is returned and never stored.
- R11: A request with source number 0 is ignored: nothing is stored and nothing is returned.
- R12: The CPPR register (bus_reg = 0) reads back the CPPR in bits [7:0], and a write to it loads the CPPR from bits [7:0].
- R13: Returned requests appear on rtn_valid/rtn_src exactly one cycle after the request is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe from source controllers |
| req_server | input | 8 | Target server number |
| req_prio | input | 8 | Request priority, 0x00 most favored |
| req_src | input | 13 | Source number {bus unit id, index} |
| avail_mask | input | 4 | Processors available for global delivery |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | 2 | Processor whose registers are addressed |
| bus_reg | input | 1 | 0 = CPPR, 1 = pending-source |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 4 | Interrupt line per processor |
| rtn_valid | output | 1 | A request is handed back |
| rtn_src | output | 13 | Source number handed back |
| eoi_valid | output | 1 | End-of-interrupt notice |
| eoi_src | output | 13 | Source whose interrupt ended |

## Verification
The assertions assume at most one bus access per cycle and at most one request per cycle. They also assume that an accepting read is never issued in the same cycle as a request that could outrank the accepted one. The bench drives requests and register accesses in separate cycles, with one operation at a time, so each step can be checked on its own. It then sweeps priority against CPPR over a grid covering both extremes, walks every non-zero available mask through several global deliveries, and tracks the expected target with its own round-robin count.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    // register select on the access bus
    typedef enum logic {
        REG_PRIO = 1'b0,
        REG_SRC  = 1'b1
    } ipc_reg_e;

    localparam int BUS_DW = 32;
endpackage

// File: rtl/ipc_rr_pick.sv
module ipc_rr_pick #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] mask,
    input  logic [W-1:0] last,
    output logic         found,
    output logic [W-1:0] pick
);
    logic [W-1:0] idx;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        idx   = '0;
        for (int k = 1; k <= N; k++) begin
            idx = W'((int'(last) + k) % N);
            if (!found && mask[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end

    // R8: the chosen processor is always one marked available
    always_comb begin
        a_r8_pick_in_mask: assert (!found || mask[pick]);
    end
endmodule

// File: rtl/ipc_cpu_unit.sv
module ipc_cpu_unit #(
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 13,
    localparam int NUM_LVL = 2 ** PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_v,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [SRC_W-1:0]  req_src,
    input  logic              wr_prio_v,
    input  logic              wr_eoi_v,
    input  logic              rd_acc_v,
    input  logic [PRIO_W-1:0] wdata_prio,
    input  logic [SRC_W-1:0]  wdata_src,
    output logic [PRIO_W-1:0] cppr,
    output logic [SRC_W-1:0]  best_src,
    output logic              irq,
    output logic              rtn_v,
    output logic [SRC_W-1:0]  rtn_src,
    output logic              eoi_v,
    output logic [SRC_W-1:0]  eoi_src
);
    typedef struct packed {
        logic [PRIO_W-1:0]                cppr;
        logic [NUM_LVL-1:0]               vld;
        logic [NUM_LVL-1:0]               busy;
        logic [NUM_LVL-1:0][SRC_W-1:0]    src;
        logic                             rtn_v;
        logic [SRC_W-1:0]                 rtn_src;
        logic                             eoi_v;
        logic [SRC_W-1:0]                 eoi_src;
    } unit_st_t;

    unit_st_t          s_q, s_d;
    logic              hit;
    logic [PRIO_W-1:0] hit_lvl;
    logic [PRIO_W-1:0] old_lvl;

    // most favored eligible slot: lowest level below CPPR, not in service
    always_comb begin
        hit     = 1'b0;
        hit_lvl = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (s_q.vld[PRIO_W'(i)] && !s_q.busy[PRIO_W'(i)] && (i < int'(s_q.cppr))) begin
                hit     = 1'b1;
                hit_lvl = PRIO_W'(i);
            end
        end
    end

    always_comb begin
        s_d         = s_q;
        s_d.rtn_v   = 1'b0;
        s_d.rtn_src = '0;
        s_d.eoi_v   = 1'b0;
        s_d.eoi_src = '0;
        old_lvl     = s_q.cppr;

        if (rd_acc_v && hit) begin
            s_d.cppr          = hit_lvl;
            s_d.busy[hit_lvl] = 1'b1;
        end

        if (wr_prio_v) begin
            s_d.cppr = wdata_prio;
        end

        if (wr_eoi_v) begin
            if (s_q.vld[old_lvl] && s_q.busy[old_lvl] && (s_q.src[old_lvl] == wdata_src)) begin
                s_d.vld[old_lvl]  = 1'b0;
                s_d.busy[old_lvl] = 1'b0;
            end
            s_d.cppr = wdata_prio;
            if (wdata_src != '0) begin
                s_d.eoi_v   = 1'b1;
                s_d.eoi_src = wdata_src;
            end
        end

        if (req_v) begin
            if (req_prio == '1) begin
                s_d.rtn_v   = 1'b1;
                s_d.rtn_src = req_src;
            end else if (!s_d.vld[req_prio]) begin
                s_d.vld[req_prio] = 1'b1;
                s_d.src[req_prio] = req_src;
            end else if (!s_d.busy[req_prio] && (req_src < s_d.src[req_prio])) begin
                s_d.rtn_v         = 1'b1;
                s_d.rtn_src       = s_d.src[req_prio];
                s_d.src[req_prio] = req_src;
            end else begin
                s_d.rtn_v   = 1'b1;
                s_d.rtn_src = req_src;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cppr     = s_q.cppr;
    assign irq      = hit;
    assign best_src = hit ? s_q.src[hit_lvl] : '0;
    assign rtn_v    = s_q.rtn_v;
    assign rtn_src  = s_q.rtn_src;
    assign eoi_v    = s_q.eoi_v;
    assign eoi_src  = s_q.eoi_src;

    // R2: loading CPPR 0x00 silences the line on the next cycle
    a_r2_zero_cppr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wr_prio_v && (wdata_prio == '0) |=> !irq);

    // R4: an accept with no competing arrival drops the line
    a_r4_accept_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc_v && irq && !req_v && !wr_prio_v && !wr_eoi_v |=> !irq);

    // R5: end-of-interrupt notice follows a non-zero write by one cycle
    a_r5_eoi_notice: assert property (@(posedge clk) disable iff (!rst_n)
        wr_eoi_v && (wdata_src != '0) |=> eoi_v && (eoi_src == $past(wdata_src)));

    // R10: least favored requests always come back
    a_r10_lowest_returned: assert property (@(posedge clk) disable iff (!rst_n)
        req_v && (req_prio == '1) |=> rtn_v && (rtn_src == $past(req_src)));
endmodule

// File: rtl/ipc_top.sv
module ipc_top #(
    parameter int               N_CPU   = 4,
    parameter int               SRV_W   = 8,
    parameter int               PRIO_W  = 8,
    parameter int               BUID_W  = 9,
    parameter int               IDX_W   = 4,
    parameter logic [SRV_W-1:0] GSERVER = '1,
    localparam int              SRC_W   = BUID_W + IDX_W,
    localparam int              CPU_W   = $clog2(N_CPU),
    localparam int              DW      = ipc_pkg::BUS_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SRV_W-1:0]  req_server,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [N_CPU-1:0]  avail_mask,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [CPU_W-1:0]  bus_cpu,
    input  logic              bus_reg,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [N_CPU-1:0]  irq,
    output logic              rtn_valid,
    output logic [SRC_W-1:0]  rtn_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src
);
    import ipc_pkg::*;

    typedef struct packed {
        logic [CPU_W-1:0] last;
        logic             rej_v;
        logic [SRC_W-1:0] rej_src;
    } top_st_t;

    top_st_t s_q, s_d;

    logic             req_ok, is_global, direct_ok, deliver;
    logic             rr_found;
    logic [CPU_W-1:0] rr_pick, target;

    logic [N_CPU-1:0]             u_req_v, u_irq, u_rtn_v, u_eoi_v;
    logic [N_CPU-1:0][PRIO_W-1:0] u_cppr;
    logic [N_CPU-1:0][SRC_W-1:0]  u_best, u_rtn_src, u_eoi_src;

    logic [PRIO_W-1:0] w_prio_hi, w_prio_lo;
    logic [SRC_W-1:0]  w_src;
    logic              unused_wbits;

    assign w_prio_hi    = bus_wdata[DW-1 -: PRIO_W];
    assign w_prio_lo    = bus_wdata[PRIO_W-1:0];
    assign w_src        = bus_wdata[SRC_W-1:0];
    assign unused_wbits = ^bus_wdata;

    ipc_rr_pick #(.N(N_CPU)) u_rr (
        .mask  (avail_mask),
        .last  (s_q.last),
        .found (rr_found),
        .pick  (rr_pick)
    );

    always_comb begin
        req_ok    = req_valid && (req_src != '0);
        is_global = (req_server == GSERVER);
        direct_ok = !is_global && (req_server < SRV_W'(N_CPU));
        target    = is_global ? rr_pick : req_server[CPU_W-1:0];
        deliver   = req_ok && (is_global ? rr_found : direct_ok);

        s_d         = s_q;
        s_d.rej_v   = 1'b0;
        s_d.rej_src = '0;
        if (req_ok && !deliver) begin
            s_d.rej_v   = 1'b1;
            s_d.rej_src = req_src;
        end
        if (req_ok && is_global && rr_found) begin
            s_d.last = rr_pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.last <= CPU_W'(N_CPU - 1);
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        logic sel_c;
        assign sel_c      = bus_sel && (bus_cpu == CPU_W'(c));
        assign u_req_v[c] = deliver && (target == CPU_W'(c));

        ipc_cpu_unit #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_unit (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_v      (u_req_v[c]),
            .req_prio   (req_prio),
            .req_src    (req_src),
            .wr_prio_v  (sel_c && bus_wr && (bus_reg == REG_PRIO)),
            .wr_eoi_v   (sel_c && bus_wr && (bus_reg == REG_SRC)),
            .rd_acc_v   (sel_c && !bus_wr && (bus_reg == REG_SRC)),
            .wdata_prio (bus_reg == REG_SRC ? w_prio_hi : w_prio_lo),
            .wdata_src  (w_src),
            .cppr       (u_cppr[c]),
            .best_src   (u_best[c]),
            .irq        (u_irq[c]),
            .rtn_v      (u_rtn_v[c]),
            .rtn_src    (u_rtn_src[c]),
            .eoi_v      (u_eoi_v[c]),
            .eoi_src    (u_eoi_src[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        rtn_valid = s_q.rej_v;
        rtn_src   = s_q.rej_src;
        eoi_valid = 1'b0;
        eoi_src   = '0;
        for (int c = 0; c < N_CPU; c++) begin
            if (bus_sel && !bus_wr && (bus_cpu == CPU_W'(c))) begin
                if (bus_reg == REG_SRC) begin
                    bus_rdata[DW-1 -: PRIO_W] = u_cppr[CPU_W'(c)];
                    bus_rdata[SRC_W-1:0]      = u_best[CPU_W'(c)];
                end else begin
                    bus_rdata[PRIO_W-1:0] = u_cppr[CPU_W'(c)];
                end
            end
            rtn_valid = rtn_valid | u_rtn_v[CPU_W'(c)];
            rtn_src   = rtn_src | u_rtn_src[CPU_W'(c)];
            eoi_valid = eoi_valid | u_eoi_v[CPU_W'(c)];
            eoi_src   = eoi_src | u_eoi_src[CPU_W'(c)];
        end
    end

    assign irq = u_irq;

    // R7: a request reaches at most one processor
    a_r7_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(u_req_v));

    // R11: source number zero reaches no processor and is not returned
    a_r11_zero_source_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_src == '0) |=> !rtn_valid);

    // R3: an empty accept reads back source zero
    a_r3_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && (bus_reg == REG_SRC) && !irq[bus_cpu]
        |-> (bus_rdata[SRC_W-1:0] == '0));

    // R9: an empty mask turns a global request around
    a_r9_empty_mask_return: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_src != '0) && (req_server == GSERVER) && (avail_mask == '0)
        |=> rtn_valid);
endmodule

// File: tb/sim_ipc_top.sv
`timescale 1ns/1ps
module sim_ipc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_server = '0;
    logic [7:0]  req_prio = '0;
    logic [12:0] req_src = '0;
    logic [3:0]  avail_mask = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_cpu = '0;
    logic        bus_reg = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        rtn_valid, eoi_valid;
    logic [12:0] rtn_src, eoi_src;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int rr_last = 3;

    always #2.5 clk = ~clk;

    ipc_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_server(req_server),
        .req_prio(req_prio), .req_src(req_src), .avail_mask(avail_mask),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_cpu(bus_cpu), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .rtn_valid(rtn_valid), .rtn_src(rtn_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] srv, input logic [7:0] pr, input logic [12:0] src);
        req_valid = 1'b1; req_server = srv; req_prio = pr; req_src = src;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic bwrite(input logic [1:0] cpu, input logic rg, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_cpu = cpu; bus_reg = rg; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [1:0] cpu, input logic rg, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_cpu = cpu; bus_reg = rg;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    // accept one expected source and end it, restoring CPPR 0xFF
    task automatic drain(input logic [1:0] cpu, input logic [12:0] src, input string tag);
        logic [31:0] d;
        bread(cpu, 1'b1, d);
        check({tag, " accept source"}, {19'd0, d[12:0]}, {19'd0, src});
        bwrite(cpu, 1'b1, {8'hFF, 11'd0, src});
        check({tag, " eoi notice"}, {18'd0, eoi_valid, eoi_src}, {18'd0, 1'b1, src});
    endtask

    function automatic int rr_next(input logic [3:0] m);
        for (int k = 1; k <= 4; k++) begin
            if (m[(rr_last + k) % 4]) return (rr_last + k) % 4;
        end
        return -1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        check("R1 irq after reset", {28'd0, irq}, 32'd0);
        check("R1 rtn/eoi after reset", {30'd0, rtn_valid, eoi_valid}, 32'd0);
        for (int c = 0; c < 4; c++) begin
            bread(2'(c), 1'b0, d);
            check("R1 R12 CPPR reset", d, 32'd0);
        end

        // R2 CPPR 0 masks; R3 empty read
        send(8'd0, 8'd0, 13'h011);
        check("R2 cppr zero masks", {28'd0, irq}, 32'd0);
        bread(2'd0, 1'b1, d);
        check("R3 empty read zero", d, 32'd0);
        bwrite(2'd0, 1'b0, 32'h0000_0001);
        check("R2 prio0 under cppr1", {28'd0, irq}, 32'd1);
        bread(2'd0, 1'b0, d);
        check("R12 CPPR readback", d, 32'd1);
        bread(2'd0, 1'b1, d);
        check("R3 R4 accept layout", d, {8'h01, 11'd0, 13'h011});
        check("R4 line drops", {28'd0, irq}, 32'd0);
        bread(2'd0, 1'b0, d);
        check("R4 CPPR raised", d, 32'd0);
        bwrite(2'd0, 1'b1, {8'hFF, 11'd0, 13'h011});
        check("R5 eoi pulse", {18'd0, eoi_valid, eoi_src}, {18'd0, 1'b1, 13'h011});
        bread(2'd0, 1'b0, d);
        check("R5 CPPR restored", d, 32'hFF);

        // R2 R10 priority against CPPR sweep on processor 1
        for (int p = 0; p < 16; p++) begin
            for (int c = 0; c < 16; c++) begin
                logic [12:0] s;
                s = {5'(c + 1), 4'(p)};
                bwrite(2'd1, 1'b0, 32'(c * 17));
                send(8'd1, 8'(p * 17), s);
                if (p == 15) begin
                    check("R10 R13 lowest returned", {18'd0, rtn_valid, rtn_src}, {18'd0, 1'b1, s});
                    check("R10 no line", {28'd0, irq}, 32'd0);
                end else begin
                    check("R2 compare", {31'd0, irq[1]}, {31'd0, p < c});
                    check("R2 no return", {31'd0, rtn_valid}, 32'd0);
                    bwrite(2'd1, 1'b0, 32'hFF);
                    drain(2'd1, s, "R4 R5 sweep");
                    check("R5 cleared", {28'd0, irq}, 32'd0);
                end
            end
        end

        // R4 ordering and nesting on processor 2
        bwrite(2'd2, 1'b0, 32'hFF);
        send(8'd2, 8'd40, 13'h0A1);
        send(8'd2, 8'd10, 13'h0B2);
        send(8'd2, 8'd90, 13'h0C3);
        bread(2'd2, 1'b1, d);
        check("R4 most favored first", d, {8'hFF, 11'd0, 13'h0B2});
        bread(2'd2, 1'b1, d);
        check("R3 nothing below new CPPR", d, {8'd10, 24'd0});
        send(8'd2, 8'd5, 13'h0D4);
        check("R2 nested raises line", {31'd0, irq[2]}, 32'd1);
        bread(2'd2, 1'b1, d);
        check("R4 nested accept", d, {8'd10, 11'd0, 13'h0D4});
        bwrite(2'd2, 1'b1, {8'd10, 11'd0, 13'h0D4});
        check("R5 nested restore keeps quiet", {31'd0, irq[2]}, 32'd0);
        bwrite(2'd2, 1'b1, {8'hFF, 11'd0, 13'h0B2});
        check("R5 outer end reopens", {31'd0, irq[2]}, 32'd1);
        drain(2'd2, 13'h0A1, "R4 second");
        drain(2'd2, 13'h0C3, "R4 third");
        check("R4 all done", {28'd0, irq}, 32'd0);

        // R6 same-level ties on processor 3
        bwrite(2'd3, 1'b0, 32'hFF);
        send(8'd3, 8'd50, 13'd20);
        check("R6 first stored", {31'd0, rtn_valid}, 32'd0);
        send(8'd3, 8'd50, 13'd10);
        check("R6 displaced returned", {18'd0, rtn_valid, rtn_src}, {18'd0, 1'b1, 13'd20});
        send(8'd3, 8'd50, 13'd30);
        check("R6 higher source returned", {18'd0, rtn_valid, rtn_src}, {18'd0, 1'b1, 13'd30});
        bread(2'd3, 1'b1, d);
        check("R6 lower source kept", {19'd0, d[12:0]}, 32'd10);
        send(8'd3, 8'd50, 13'd5);
        check("R6 in-service slot returns", {18'd0, rtn_valid, rtn_src}, {18'd0, 1'b1, 13'd5});
        // R5 mismatched end leaves the slot in service
        bwrite(2'd3, 1'b1, {8'hFF, 11'd0, 13'd99});
        check("R5 mismatch notice", {18'd0, eoi_valid, eoi_src}, {18'd0, 1'b1, 13'd99});
        send(8'd3, 8'd50, 13'd7);
        check("R5 mismatch slot kept", {18'd0, rtn_valid, rtn_src}, {18'd0, 1'b1, 13'd7});
        bwrite(2'd3, 1'b0, 32'd50);
        bwrite(2'd3, 1'b1, {8'hFF, 11'd0, 13'd10});
        send(8'd3, 8'd50, 13'd7);
        check("R5 slot freed", {31'd0, rtn_valid}, 32'd0);
        drain(2'd3, 13'd7, "R6 cleanup");

        // R7 unknown server, R11 source zero
        send(8'd9, 8'd3, 13'h055);
        check("R7 bad server returned", {18'd0, rtn_valid, rtn_src}, {18'd0, 1'b1, 13'h055});
        send(8'd1, 8'd3, 13'd0);
        check("R11 zero source line", {28'd0, irq}, 32'd0);
        check("R11 zero source no return", {31'd0, rtn_valid}, 32'd0);

        // R8 R9 global delivery
        avail_mask = 4'b0000;
        send(8'hFF, 8'd20, 13'h077);
        check("R9 empty mask returned", {18'd0, rtn_valid, rtn_src}, {18'd0, 1'b1, 13'h077});
        for (int m = 1; m < 16; m++) begin
            for (int r = 0; r < 3; r++) begin
                int t;
                logic [12:0] s;
                s = 13'(m * 4 + r + 1);
                avail_mask = 4'(m);
                t = rr_next(4'(m));
                send(8'hFF, 8'd20, s);
                check("R8 global target", {28'd0, irq}, 32'(1 << t));
                rr_last = t;
                drain(2'(t), s, "R8 global");
            end
        end
        avail_mask = 4'b0000;
        send(8'hFF, 8'd20, 13'h078);
        check("R9 returned again", {31'd0, rtn_valid}, 32'd1);
        avail_mask = 4'b1111;
        send(8'hFF, 8'd20, 13'h079);
        check("R9 pointer unchanged", {28'd0, irq}, 32'(1 << ((rr_last + 1) % 4)));
        drain(2'((rr_last + 1) % 4), 13'h079, "R9 cleanup");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule